// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic fabric. A primary input vector is expanded into literals, the true and the inverted copy of every input, and a product-term plane ANDs together whichever literals the configuration selects. An OR stage then combines product terms into outputs. A parameter chooses between two array kinds. In the freely routed kind, a programmable connection plane lets any term feed any output. In the grouped kind, the connection plane is absent and each output ORs its own fixed run of consecutive terms.

Every output has a mode bit. The bit either passes the OR result straight through or takes it from a flip-flop, so that state machines and other sequential circuits can be built around the array. The whole configuration image is shifted in serially, one bit per clock, while the load enable is high. All outputs are forced low during a load, and the output flip-flops are cleared.

Top module: `pla_logic_array`

## Requirements
- R1: Product term t ANDs the literals it selects. Inside the image, term t owns bits [t*2N +: 2N], where N is the input count. Bit t*2N+2i selects input i in its true form, and bit t*2N+2i+1 selects it inverted.
- R2: A product term that selects no literal evaluates to 1.
- R3: A product term that selects both the true and the inverted form of the same input evaluates to 0.
- R4: In the freely routed kind, image bit 2NT + o*T + t (T terms) connects term t to output o. An output with no connected term is 0.
- R5: In the grouped kind, the image has no connection plane. Output o is the OR of terms o*T/M through o*T/M + T/M - 1, where M is the output count. With the defaults this is terms 2o and 2o+1.
- R6: The mode bits are the last M bits of the image, at offset 2NT + 4T in the routed kind and 2NT in the grouped kind. A mode bit of 0 makes output o follow the OR result in the same cycle. A mode bit of 1 makes output o show the OR result captured at the previous clock edge.
- R7: While cfgEn is high, each clock shifts cfgBit into the top of the image and moves every other bit down by one place. After a full load, the first bit sent therefore sits at index 0. While cfgEn is low, cfgBit has no effect on the image or on the outputs.
- R8: While cfgEn is high, every output is 0 and every output flip-flop is cleared. A registered output therefore reads 0 in the first cycle after cfgEn falls.
- R9: A synchronous reset clears the image and the flip-flops. After reset, routed-kind outputs read all 0 and grouped-kind outputs read all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Serial load enable |
| cfgBit | input | 1 | Serial configuration data, one bit per clock |
| dataIn | input | NUM_IN | Primary inputs |
| dataOut | output | NUM_OUT | Array outputs |

## Verification
Combinational outputs respond to dataIn and cfgEn within the same cycle, with no edge between stimulus and result. A registered output reflects the OR value present at the previous rising edge, and a configuration bit takes effect only at the edge that shifts it in. The bench changes its inputs just after each rising edge, advances its reference model at the same rising edge as the design, and compares at the following falling edge. Each comparison therefore sees combinational results of the new inputs and registered results of the previous edge.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  typedef enum logic {
    ARRAY_PLA = 1'b0,
    ARRAY_PAL = 1'b1
  } arrayKind_e;

  typedef struct packed {
    logic chainClear;
    logic shiftEn;
    logic regClear;
    logic outMask;
  } ctrlStrobe_t;

  function automatic int chainLength(input int nIn, input int nTerms, input int nOut,
                                     input arrayKind_e kind);
    return 2 * nIn * nTerms + ((kind == ARRAY_PLA) ? nOut * nTerms : 0) + nOut;
  endfunction

endpackage

// File: rtl/pla_ctrl.sv
`timescale 1ns/1ps
module pla_ctrl
  import pla_pkg::*;
(
  input  logic        rst,
  input  logic        cfgEn,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.chainClear = rst;
    strobe.shiftEn    = cfgEn & ~rst;
    strobe.regClear   = rst | cfgEn;
    strobe.outMask    = cfgEn & ~rst;
  end

endmodule

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
module pla_cfg_chain #(
  parameter int LEN = 132
) (
  input  logic           clk,
  input  logic           chainClear,
  input  logic           shiftEn,
  input  logic           cfgBit,
  output logic [LEN-1:0] image
);

  always_ff @(posedge clk) begin
    if (chainClear)   image <= '0;
    else if (shiftEn) image <= {cfgBit, image[LEN-1:1]};
  end

  // R7: image frozen when not shifting
  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (chainClear)
    !shiftEn |=> $stable(image));

  // R7: newest bit enters at the top
  assert_chain_shift_R7: assert property (@(posedge clk) disable iff (chainClear)
    shiftEn |=> image[LEN-1] == $past(cfgBit));

  // R9: reset empties the image
  assert_chain_reset_R9: assert property (@(posedge clk) disable iff (chainClear)
    $past(chainClear) |-> image == '0);

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int NUM_IN    = 6,
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_IN-1:0]             dataIn,
  input  logic [2*NUM_IN*NUM_TERMS-1:0] andCfg,
  output logic [NUM_TERMS-1:0]          termVec
);

  localparam int LIT_W = 2 * NUM_IN;

  logic [LIT_W-1:0] literals;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literals[2*i]   = dataIn[i];
    assign literals[2*i+1] = ~dataIn[i];
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign termVec[t] = &(literals | ~andCfg[t*LIT_W +: LIT_W]);
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int NUM_TERMS = 8,
  parameter int NUM_OUT   = 4
) (
  input  logic [NUM_TERMS-1:0]         termVec,
  input  logic [NUM_OUT*NUM_TERMS-1:0] orMask,
  output logic [NUM_OUT-1:0]           orVec
);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
    assign orVec[o] = |(termVec & orMask[o*NUM_TERMS +: NUM_TERMS]);
  end

endmodule

// File: rtl/pla_out_stage.sv
`timescale 1ns/1ps
module pla_out_stage #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               regClear,
  input  logic               outMask,
  input  logic [NUM_OUT-1:0] orVec,
  input  logic [NUM_OUT-1:0] modeBits,
  output logic [NUM_OUT-1:0] dataOut
);

  logic [NUM_OUT-1:0] regQ;

  always_ff @(posedge clk) begin
    if (regClear) regQ <= '0;
    else          regQ <= orVec;
  end

  always_comb begin
    if (outMask) dataOut = '0;
    else         dataOut = (modeBits & regQ) | (~modeBits & orVec);
  end

  // R8: flops come out of a load or reset empty
  assert_reg_cleared_R8: assert property (@(posedge clk) disable iff (regClear)
    $past(regClear) |-> regQ == '0);

endmodule

// File: rtl/pla_datapath.sv
`timescale 1ns/1ps
module pla_datapath
  import pla_pkg::*;
#(
  parameter int         NUM_IN     = 6,
  parameter int         NUM_TERMS  = 8,
  parameter int         NUM_OUT    = 4,
  parameter arrayKind_e ARRAY_KIND = ARRAY_PLA
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobe,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);

  localparam int AND_BITS      = 2 * NUM_IN * NUM_TERMS;
  localparam int MASK_BITS     = NUM_OUT * NUM_TERMS;
  localparam int CHAIN_LEN     = chainLength(NUM_IN, NUM_TERMS, NUM_OUT, ARRAY_KIND);
  localparam int MODE_BASE     = CHAIN_LEN - NUM_OUT;
  localparam int TERMS_PER_OUT = NUM_TERMS / NUM_OUT;

  logic [CHAIN_LEN-1:0] image;
  logic [NUM_TERMS-1:0] termVec;
  logic [MASK_BITS-1:0] orMask;
  logic [NUM_OUT-1:0]   orVec;

  pla_cfg_chain #(.LEN(CHAIN_LEN)) i_chain (
    .clk        (clk),
    .chainClear (strobe.chainClear),
    .shiftEn    (strobe.shiftEn),
    .cfgBit     (cfgBit),
    .image      (image)
  );

  pla_and_plane #(.NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS)) i_and (
    .dataIn  (dataIn),
    .andCfg  (image[AND_BITS-1:0]),
    .termVec (termVec)
  );

  if (ARRAY_KIND == ARRAY_PLA) begin : g_routed
    assign orMask = image[AND_BITS +: MASK_BITS];
  end else begin : g_grouped
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      for (genvar t = 0; t < NUM_TERMS; t++) begin : g_trm
        assign orMask[o*NUM_TERMS + t] = ((t / TERMS_PER_OUT) == o) ? 1'b1 : 1'b0;
      end
    end
  end

  pla_or_plane #(.NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT)) i_or (
    .termVec (termVec),
    .orMask  (orMask),
    .orVec   (orVec)
  );

  pla_out_stage #(.NUM_OUT(NUM_OUT)) i_out (
    .clk      (clk),
    .regClear (strobe.regClear),
    .outMask  (strobe.outMask),
    .orVec    (orVec),
    .modeBits (image[MODE_BASE +: NUM_OUT]),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/pla_logic_array.sv
`timescale 1ns/1ps
module pla_logic_array
  import pla_pkg::*;
#(
  parameter int         NUM_IN     = 6,
  parameter int         NUM_TERMS  = 8,
  parameter int         NUM_OUT    = 4,
  parameter arrayKind_e ARRAY_KIND = ARRAY_PLA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgEn,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);

  ctrlStrobe_t strobe;

  pla_ctrl i_ctrl (
    .rst    (rst),
    .cfgEn  (cfgEn),
    .strobe (strobe)
  );

  pla_datapath #(
    .NUM_IN     (NUM_IN),
    .NUM_TERMS  (NUM_TERMS),
    .NUM_OUT    (NUM_OUT),
    .ARRAY_KIND (ARRAY_KIND)
  ) i_dp (
    .clk     (clk),
    .strobe  (strobe),
    .cfgBit  (cfgBit),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // R8: loading silences every output
  assert_out_masked_R8: assert property (@(posedge clk) disable iff (rst)
    cfgEn |-> dataOut == '0);

endmodule

// File: tb/test_pla_logic_array.sv
`timescale 1ns/1ps
module test_pla_logic_array;
  import pla_pkg::*;

  localparam int N     = 6;
  localparam int T     = 8;
  localparam int O     = 4;
  localparam int TPO   = T / O;
  localparam int AW    = 2 * N * T;
  localparam int PLA_L = AW + O * T + O;
  localparam int PAL_L = AW + O;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic [N-1:0] dataIn = '0;
  logic         plaCfgEn = 1'b0, plaCfgBit = 1'b0;
  logic         palCfgEn = 1'b0, palCfgBit = 1'b0;
  logic [O-1:0] plaOut, palOut;

  pla_logic_array #(.NUM_IN(N), .NUM_TERMS(T), .NUM_OUT(O), .ARRAY_KIND(ARRAY_PLA)) i_pla_logic_array (
    .clk(clk), .rst(rst), .cfgEn(plaCfgEn), .cfgBit(plaCfgBit), .dataIn(dataIn), .dataOut(plaOut));

  pla_logic_array #(.NUM_IN(N), .NUM_TERMS(T), .NUM_OUT(O), .ARRAY_KIND(ARRAY_PAL)) i_pal_logic_array (
    .clk(clk), .rst(rst), .cfgEn(palCfgEn), .cfgBit(palCfgBit), .dataIn(dataIn), .dataOut(palOut));

  int    checks = 0;
  int    errors = 0;
  bit    checking = 1'b0;
  string curReq = "R9";

  // behavioural reference state
  logic [PLA_L-1:0] plaImg = '0;
  logic [PLA_L-1:0] palImg = '0;   // only low PAL_L bits used
  logic [O-1:0]     plaReg = '0, palReg = '0;

  function automatic logic [O-1:0] modelComb(input logic [PLA_L-1:0] img, input logic [N-1:0] din, input bit pal);
    logic [T-1:0] term;
    logic [O-1:0] r;
    for (int t = 0; t < T; t++) begin
      term[t] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (img[t*2*N + 2*i]   && !din[i]) term[t] = 1'b0;
        if (img[t*2*N + 2*i+1] &&  din[i]) term[t] = 1'b0;
      end
    end
    r = '0;
    for (int o = 0; o < O; o++) begin
      if (pal) begin
        for (int k = 0; k < TPO; k++) if (term[o*TPO + k]) r[o] = 1'b1;
      end else begin
        for (int t = 0; t < T; t++) if (img[AW + o*T + t] && term[t]) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [O-1:0] expOut(input logic [PLA_L-1:0] img, input logic [N-1:0] din,
                                          input bit pal, input logic en, input logic [O-1:0] regs);
    logic [O-1:0] m;
    m = pal ? img[AW +: O] : img[AW + O*T +: O];
    if (en) return '0;
    return (m & regs) | (~m & modelComb(img, din, pal));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      plaImg = '0; palImg = '0; plaReg = '0; palReg = '0;
    end else begin
      if (plaCfgEn) begin plaImg = {plaCfgBit, plaImg[PLA_L-1:1]}; plaReg = '0; end
      else plaReg = modelComb(plaImg, dataIn, 1'b0);
      if (palCfgEn) begin palImg[PAL_L-1:0] = {palCfgBit, palImg[PAL_L-1:1]}; palReg = '0; end
      else palReg = modelComb(palImg, dataIn, 1'b1);
    end
  end

  task automatic checkOne(input string who, input logic [O-1:0] got, input logic [O-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", curReq, who, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      checkOne("routed", plaOut, expOut(plaImg, dataIn, 1'b0, plaCfgEn, plaReg));
      checkOne("grouped", palOut, expOut(palImg, dataIn, 1'b1, palCfgEn, palReg));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic loadPla(input logic [PLA_L-1:0] img);
    curReq = "R7 R8 routed load";
    for (int k = 0; k < PLA_L; k++) begin step(); plaCfgEn = 1'b1; plaCfgBit = img[k]; end
    step(); plaCfgEn = 1'b0; plaCfgBit = 1'b0;
  endtask

  task automatic loadPal(input logic [PLA_L-1:0] img);
    curReq = "R7 R8 grouped load";
    for (int k = 0; k < PAL_L; k++) begin step(); palCfgEn = 1'b1; palCfgBit = img[k]; end
    step(); palCfgEn = 1'b0; palCfgBit = 1'b0;
  endtask

  // cfgBit toggles while cfgEn is low: R7 says it is ignored
  task automatic sweep(input string req);
    curReq = req;
    for (int v = 0; v < 64; v++) begin
      step();
      dataIn    = N'((v * 37 + 5) % 64);
      plaCfgBit = 1'($urandom % 2);
      palCfgBit = 1'($urandom % 2);
    end
    plaCfgBit = 1'b0; palCfgBit = 1'b0;
  endtask

  function automatic int andIdx(input int t, input int i, input int comp);
    return t*2*N + 2*i + comp;
  endfunction

  function automatic logic [PLA_L-1:0] randImg(input bit pal);
    logic [PLA_L-1:0] img = '0;
    int len = pal ? PAL_L : PLA_L;
    for (int k = 0; k < len; k++)
      img[k] = (k < AW) ? (($urandom % 6) == 0) : 1'($urandom % 2);
    return img;
  endfunction

  initial begin
    logic [PLA_L-1:0] img;
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PLA_L-1:0] img;
    @(posedge clk); #1;
    checking = 1'b1;
    curReq = "R9 reset state";
    repeat (3) step();
    rst = 1'b0;
    sweep("R9 reset image");

    // routed image 1: R1 R2 R3 R4 R6
    img = '0;
    img[andIdx(0,0,0)] = 1; img[andIdx(0,1,1)] = 1;          // t0 = a0 & ~a1
    img[andIdx(1,2,0)] = 1;                                  // t1 = a2
    // t2 empty -> 1 (R2)
    img[andIdx(3,3,0)] = 1; img[andIdx(3,3,1)] = 1;          // t3 contradiction -> 0 (R3)
    img[andIdx(4,4,0)] = 1; img[andIdx(4,5,0)] = 1;          // t4 = a4 & a5
    img[andIdx(5,4,1)] = 1; img[andIdx(5,5,1)] = 1;          // t5 = ~a4 & ~a5
    img[andIdx(6,0,0)] = 1; img[andIdx(7,1,1)] = 1;
    img[AW + 0*T + 0] = 1; img[AW + 0*T + 1] = 1;            // out0 = t0|t1
    img[AW + 1*T + 2] = 1;                                   // out1 = t2
    img[AW + 2*T + 3] = 1;                                   // out2 = t3
    img[AW + 3*T + 4] = 1; img[AW + 3*T + 5] = 1;            // out3 = t4|t5
    img[AW + O*T + 1] = 1; img[AW + O*T + 3] = 1;            // out1, out3 registered
    loadPla(img);
    sweep("R1 R2 R3 R4 R6 routed");

    // grouped image: R5
    img = '0;
    img[andIdx(0,0,0)] = 1; img[andIdx(1,0,1)] = 1;          // out0 = a0 | ~a0
    img[andIdx(2,1,0)] = 1; img[andIdx(2,2,0)] = 1;          // t2 = a1 & a2
    img[andIdx(3,3,1)] = 1;                                  // t3 = ~a3
    img[andIdx(4,5,0)] = 1; img[andIdx(4,5,1)] = 1;          // t4 = 0
    img[andIdx(5,4,0)] = 1; img[andIdx(5,1,1)] = 1;          // t5 = a4 & ~a1
    img[andIdx(6,0,0)] = 1; img[andIdx(6,1,0)] = 1; img[andIdx(6,2,0)] = 1;
    img[andIdx(7,5,1)] = 1;
    img[AW + 3] = 1; img[AW + 0] = 1;                        // out0, out3 registered
    loadPal(img);
    sweep("R1 R3 R5 R6 grouped");

    // routed image 2: output without terms, all combinational (R4)
    img = '0;
    img[andIdx(0,0,0)] = 1; img[andIdx(1,1,1)] = 1; img[andIdx(2,2,0)] = 1; img[andIdx(2,3,0)] = 1;
    img[AW + 0*T + 0] = 1; img[AW + 1*T + 1] = 1; img[AW + 1*T + 2] = 1;
    img[AW + 3*T + 0] = 1; img[AW + 3*T + 1] = 1; img[AW + 3*T + 2] = 1;
    loadPla(img);
    sweep("R4 R6 routed empty output");

    for (int r = 0; r < 3; r++) begin
      loadPla(randImg(1'b0));
      loadPal(randImg(1'b1));
      sweep("R1 R4 R5 R6 random images");
    end

    // reset after configuration
    curReq = "R9 reset after load";
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    sweep("R9 reset after load");

    checking = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule